// File: doc/BRIEF.md
# Planar Write Color Expansion Unit

This block sits in the CPU write path of a display controller whose frame buffer is split into four bit planes. For every write it turns one CPU byte plus a handful of control register values into four plane data bytes and four per-bit write enables. The memory sequencer then applies those bytes and enables to the addressed location in each plane. The standard ALU and logical operations and the memory timing are handled elsewhere.

The data source follows one of three write styles, chosen by a two-bit mode code. PASS sends the CPU byte unchanged to every plane, and code 3 (RSVD) is handled the same way. EXPAND turns a monochrome byte into color: each set bit writes the foreground color and each clear bit writes the background color, with color bit n going to plane n. DITHER replaces each plane's byte with that plane's foreground latch. The mask source follows one of three mask kinds: MSK_OFF enables every bit, MSK_REG uses a fixed mask register, and MSK_ROT uses the CPU byte rotated right. The selected mode and mask kind are decoded fresh on every cycle from the inputs. Any mode or kind can therefore follow any other on the next cycle, with no intermediate state. Both outputs are registered, so each result is due one clock after its inputs.

Top module: `planar_color_expand`

## Requirements
- R1: While rst_n is low, plane_data and plane_mask are both all zeros.
- R2: With mode_sel = 0 (PASS), every plane byte of plane_data equals cpu_byte.
- R3: mode_sel = 3 produces the same plane_data as mode_sel = 0.
- R4: With mode_sel = 2 (DITHER), plane n of plane_data (bits 8n+7..8n) equals fg_latch bits 8n+7..8n.
- R5: With mode_sel = 1 (EXPAND), bit b of plane n is fg_color[n] when source bit b is 1 and bg_color[n] when source bit b is 0.
- R6: The expansion source is cpu_byte when src_cpu = 1 and pattern_reg when src_cpu = 0. pattern_reg has no effect on plane_data outside EXPAND.
- R7: When mask_ctrl[0] = 0, every bit of plane_mask is 1, whatever mask_reg, mask_ctrl[1] and rot_cnt hold.
- R8: When mask_ctrl = 2'b01, every plane byte of plane_mask equals mask_reg.
- R9: When mask_ctrl = 2'b11, every plane byte of plane_mask equals cpu_byte rotated right by rot_cnt (0 to 7), and mask_reg has no effect.
- R10: plane_data and plane_mask show the result for the inputs sampled at a rising clock edge from that edge until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_byte | input | 8 | Byte written by the CPU |
| rot_cnt | input | 3 | Right-rotate count applied to the CPU byte when it is used as a mask |
| mode_sel | input | 2 | Write style: 0 PASS, 1 EXPAND, 2 DITHER, 3 RSVD (treated as PASS) |
| src_cpu | input | 1 | Expansion source: 1 for the CPU byte, 0 for the pattern register |
| pattern_reg | input | 8 | Pattern register used as the expansion source |
| fg_color | input | 4 | Foreground color; bit n goes to plane n |
| bg_color | input | 4 | Background color; bit n goes to plane n |
| fg_latch | input | 32 | Four foreground latches; plane n in bits 8n+7..8n |
| mask_ctrl | input | 2 | Bit 0 enables masking; bit 1 selects the rotated CPU byte as the mask |
| mask_reg | input | 8 | Fixed write mask |
| plane_data | output | 32 | Per-plane write data; plane n in bits 8n+7..8n |
| plane_mask | output | 32 | Per-plane bit write enables; plane n in bits 8n+7..8n |

## Verification
Every result has a latency of exactly one clock: inputs captured at a rising edge appear on plane_data and plane_mask right after that edge. The bench changes inputs at a falling edge, waits for the next rising edge, and samples at the following falling edge, halfway between edges. The latency test also samples just before the rising edge to confirm that the old result is still held there and the new one appears only afterwards. The assertions compare each output with the input captured one edge earlier through $past, which matches the same one-cycle timing.

// File: rtl/pce_pkg.sv
package pce_pkg;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_EXPAND = 2'd1,
        MODE_DITHER = 2'd2,
        MODE_RSVD   = 2'd3
    } pce_mode_e;

    typedef enum logic [1:0] {
        MSK_OFF = 2'd0,
        MSK_REG = 2'd1,
        MSK_ROT = 2'd2
    } pce_mask_e;

endpackage

// File: rtl/pce_rotr.sv
module pce_rotr #(
    parameter int WIDTH = 8,
    localparam int ROT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [ROT_W-1:0] amount,
    output logic [WIDTH-1:0] dout
);

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            dout[i] = din[(i + int'(amount)) % WIDTH];
        end
    end

endmodule

// File: rtl/pce_lane.sv
module pce_lane
    import pce_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  pce_mode_e         mode,
    input  logic [LANE_W-1:0] cpu_byte,
    input  logic [LANE_W-1:0] exp_src,
    input  logic              fg_bit,
    input  logic              bg_bit,
    input  logic [LANE_W-1:0] latch_byte,
    output logic [LANE_W-1:0] lane_data
);

    logic [LANE_W-1:0] expanded;

    genvar b;
    generate
        for (b = 0; b < LANE_W; b++) begin : g_bit
            assign expanded[b] = exp_src[b] ? fg_bit : bg_bit;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_EXPAND: lane_data = expanded;
            MODE_DITHER: lane_data = latch_byte;
            default:     lane_data = cpu_byte;
        endcase
    end

endmodule

// File: rtl/pce_mask_sel.sv
module pce_mask_sel
    import pce_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  pce_mask_e         kind,
    input  logic [LANE_W-1:0] fixed_mask,
    input  logic [LANE_W-1:0] rot_mask,
    output logic [LANE_W-1:0] lane_mask
);

    always_comb begin
        unique case (kind)
            MSK_REG: lane_mask = fixed_mask;
            MSK_ROT: lane_mask = rot_mask;
            default: lane_mask = '1;
        endcase
    end

endmodule

// File: rtl/planar_color_expand.sv
module planar_color_expand
    import pce_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int LANE_W = 8,
    localparam int ROT_W  = $clog2(LANE_W),
    localparam int DATA_W = PLANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] cpu_byte,
    input  logic [ROT_W-1:0]  rot_cnt,
    input  logic [1:0]        mode_sel,
    input  logic              src_cpu,
    input  logic [LANE_W-1:0] pattern_reg,
    input  logic [PLANES-1:0] fg_color,
    input  logic [PLANES-1:0] bg_color,
    input  logic [DATA_W-1:0] fg_latch,
    input  logic [1:0]        mask_ctrl,
    input  logic [LANE_W-1:0] mask_reg,
    output logic [DATA_W-1:0] plane_data,
    output logic [DATA_W-1:0] plane_mask
);

    pce_mode_e         mode_eff;
    pce_mask_e         mask_kind;
    logic [LANE_W-1:0] exp_src;
    logic [LANE_W-1:0] rot_byte;
    logic [LANE_W-1:0] lane_mask;
    logic [DATA_W-1:0] data_nxt;
    logic [DATA_W-1:0] mask_nxt;

    // Mode decode: RSVD folds onto PASS
    always_comb begin
        unique case (pce_mode_e'(mode_sel))
            MODE_EXPAND: mode_eff = MODE_EXPAND;
            MODE_DITHER: mode_eff = MODE_DITHER;
            default:     mode_eff = MODE_PASS;
        endcase
    end

    // Mask kind decode
    always_comb begin
        unique case (mask_ctrl)
            2'b01:   mask_kind = MSK_REG;
            2'b11:   mask_kind = MSK_ROT;
            default: mask_kind = MSK_OFF;
        endcase
    end

    assign exp_src = src_cpu ? cpu_byte : pattern_reg;

    pce_rotr #(.WIDTH(LANE_W)) u_rotr (
        .din    (cpu_byte),
        .amount (rot_cnt),
        .dout   (rot_byte)
    );

    pce_mask_sel #(.LANE_W(LANE_W)) u_mask (
        .kind       (mask_kind),
        .fixed_mask (mask_reg),
        .rot_mask   (rot_byte),
        .lane_mask  (lane_mask)
    );

    genvar p;
    generate
        for (p = 0; p < PLANES; p++) begin : g_plane
            pce_lane #(.LANE_W(LANE_W)) u_lane (
                .mode       (mode_eff),
                .cpu_byte   (cpu_byte),
                .exp_src    (exp_src),
                .fg_bit     (fg_color[p]),
                .bg_bit     (bg_color[p]),
                .latch_byte (fg_latch[p*LANE_W +: LANE_W]),
                .lane_data  (data_nxt[p*LANE_W +: LANE_W])
            );
            assign mask_nxt[p*LANE_W +: LANE_W] = lane_mask;
        end
    endgenerate

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_data <= '0;
            plane_mask <= '0;
        end else begin
            plane_data <= data_nxt;
            plane_mask <= mask_nxt;
        end
    end

    AST_MASK_OFF_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_ctrl[0] |=> (plane_mask == '1)); // R7

    AST_MASK_REG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_ctrl == 2'b01) |=> (plane_mask[LANE_W-1:0] == $past(mask_reg))); // R8

    AST_DITHER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2) |=> (plane_data == $past(fg_latch))); // R4

    AST_PASS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0 || mode_sel == 2'd3) |=>
        (plane_data[LANE_W-1:0] == $past(cpu_byte))); // R3

    AST_MASK_ZERO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_ctrl == 2'b11 && rot_cnt == '0) |=>
        (plane_mask[DATA_W-1 -: LANE_W] == $past(cpu_byte))); // R9

endmodule

// File: tb/tb_planar_color_expand.sv
`timescale 1ns/1ps
module tb_planar_color_expand;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cpu_byte;
    logic [2:0]  rot_cnt;
    logic [1:0]  mode_sel;
    logic        src_cpu;
    logic [7:0]  pattern_reg;
    logic [3:0]  fg_color;
    logic [3:0]  bg_color;
    logic [31:0] fg_latch;
    logic [1:0]  mask_ctrl;
    logic [7:0]  mask_reg;
    logic [31:0] plane_data;
    logic [31:0] plane_mask;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    planar_color_expand dut (
        .clk(clk), .rst_n(rst_n), .cpu_byte(cpu_byte), .rot_cnt(rot_cnt),
        .mode_sel(mode_sel), .src_cpu(src_cpu), .pattern_reg(pattern_reg),
        .fg_color(fg_color), .bg_color(bg_color), .fg_latch(fg_latch),
        .mask_ctrl(mask_ctrl), .mask_reg(mask_reg),
        .plane_data(plane_data), .plane_mask(plane_mask)
    );

    function automatic logic [31:0] model_data();
        logic [31:0] r;
        logic [7:0]  s;
        s = src_cpu ? cpu_byte : pattern_reg;
        for (int n = 0; n < 4; n++) begin
            for (int b = 0; b < 8; b++) begin
                case (mode_sel)
                    2'd1:    r[n*8+b] = s[b] ? fg_color[n] : bg_color[n];
                    2'd2:    r[n*8+b] = fg_latch[n*8+b];
                    default: r[n*8+b] = cpu_byte[b];
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] model_mask();
        logic [15:0] w;
        logic [7:0]  m;
        w = {cpu_byte, cpu_byte} >> rot_cnt;
        if (!mask_ctrl[0])      m = 8'hFF;
        else if (mask_ctrl[1])  m = w[7:0];
        else                    m = mask_reg;
        return {4{m}};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Apply current inputs: they are sampled at the next rising edge, checked at the following falling edge.
    task automatic step_and_check(string req);
        logic [31:0] ed, em;
        ed = model_data();
        em = model_mask();
        @(posedge clk);
        @(negedge clk);
        check({req, " data"}, plane_data, ed);
        check({req, " mask"}, plane_mask, em);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cpu_byte = 8'h5A; rot_cnt = 3'd1; mode_sel = 2'd0; src_cpu = 1'b1;
        pattern_reg = 8'h00; fg_color = 4'h0; bg_color = 4'h0;
        fg_latch = 32'h0; mask_ctrl = 2'b00; mask_reg = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 data", plane_data, 32'h0);
        check("R1 mask", plane_mask, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_pass();
        mode_sel = 2'd0; cpu_byte = 8'h3C; pattern_reg = 8'hF0; src_cpu = 1'b0;
        step_and_check("R2");
        cpu_byte = 8'h81;
        step_and_check("R2");
        mode_sel = 2'd3; cpu_byte = 8'hE7;
        step_and_check("R3");
        check("R3 value", plane_data, 32'hE7E7E7E7);
    endtask

    task automatic t_dither();
        mode_sel = 2'd2; fg_latch = 32'hA55A3CC3; cpu_byte = 8'h11;
        step_and_check("R4");
        check("R4 value", plane_data, 32'hA55A3CC3);
        fg_latch = 32'h0102FF80; pattern_reg = 8'h77;
        step_and_check("R4 R6 pattern ignored");
    endtask

    task automatic t_expand();
        mode_sel = 2'd1; src_cpu = 1'b1; cpu_byte = 8'hB4; pattern_reg = 8'h0F;
        fg_color = 4'b1010; bg_color = 4'b0110;
        step_and_check("R5");
        check("R5 value", plane_data, 32'hB44BFF00);
        src_cpu = 1'b0;
        step_and_check("R6 pattern source");
        check("R6 value", plane_data, 32'h0FF0FF00);
        fg_color = 4'hF; bg_color = 4'h0; pattern_reg = 8'h00;
        step_and_check("R5 all background");
        pattern_reg = 8'hFF;
        step_and_check("R5 all foreground");
    endtask

    task automatic t_mask_off();
        mode_sel = 2'd0; mask_ctrl = 2'b00; mask_reg = 8'h12; rot_cnt = 3'd5;
        step_and_check("R7");
        mask_ctrl = 2'b10;
        step_and_check("R7 bit1 alone");
        check("R7 value", plane_mask, 32'hFFFFFFFF);
    endtask

    task automatic t_mask_reg();
        mask_ctrl = 2'b01; mask_reg = 8'hC6; cpu_byte = 8'h01;
        step_and_check("R8");
        mask_reg = 8'h00;
        step_and_check("R8 zero mask");
    endtask

    task automatic t_mask_rot();
        mask_ctrl = 2'b11; cpu_byte = 8'h01; mask_reg = 8'hAA;
        for (int r = 0; r < 8; r++) begin
            rot_cnt = 3'(r);
            step_and_check("R9");
        end
        cpu_byte = 8'hC3; rot_cnt = 3'd2;
        step_and_check("R9");
        check("R9 value", plane_mask, 32'hF0F0F0F0);
    endtask

    task automatic t_latency();
        logic [31:0] old_d, new_d;
        mode_sel = 2'd0; mask_ctrl = 2'b00; cpu_byte = 8'h55;
        step_and_check("R10 setup");
        old_d = plane_data;
        cpu_byte = 8'hAA;
        new_d = model_data();
        #1;
        check("R10 hold before edge", plane_data, old_d);
        @(posedge clk);
        #1;
        check("R10 update after edge", plane_data, new_d);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_pass();
        t_dither();
        t_expand();
        t_mask_off();
        t_mask_reg();
        t_mask_rot();
        t_latency();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule